// File: doc/BRIEF.md
# Two-Stage Watchdog Timer Register Block

This block is a watchdog timer that a host programs through a small synchronous register port with byte enables. A down counter, 10 bits wide by default, advances on a one-cycle tick strobe that supplies the timebase. With a 0.6 s tick, a timeout of S seconds needs S*10/6 ticks. Software sets the start value in an initial-value register. Any write to the reload register copies that value, masked to the counter width, into the live counter. Reading the reload register returns the live count.

When the count runs out, the timeout flag in status register 1 is set and the counter restarts from the initial value. If the count runs out again before software has written the reload register, status register 2 records a second timeout and a boot status. In that case, if the external no-reboot input is low, the block also gives a one-cycle action request. Control register 1 holds a halt bit that freezes the counter and a lock bit that only reset clears. Every status bit is cleared by writing a one to it. Several byte registers act as plain storage for a management mailbox. A write to either data byte sets a software-event status bit.

Top module: `wdog_regs`

## Requirements
- R1: After reset, reads return 0x0004 at offset 0x12 (initial value), 0x0008 at 0x0A (control 2) and 0x0003 at 0x10 (software interrupt). Every other offset (0x00, 0x02, 0x04, 0x06, 0x08, 0x0C, 0x0E) reads 0.
- R2: A write with any byte enable to offset 0x00 loads the initial value, masked to the counter width, into the live counter. A read of offset 0x00 returns the live count.
- R3: The live count drops by one on each tick while bit 11 (halt) of control register 1 at 0x08 is clear. It holds while that bit is set.
- R4: A tick with halt clear and a live count of 1 (or 0) is an expiry. An expiry sets bit 3 of status 1 at 0x04 and reloads the counter from the masked initial value. After loading N, bit 3 is still clear after N-1 ticks and is set after the Nth tick.
- R5: An expiry that follows an earlier expiry, with no reload write in between, sets bits 1 (second timeout) and 2 (boot status) of status 2 at 0x06. This happens even if software has cleared bit 3 of status 1.
- R6: On such a second expiry, output action_req pulses high for exactly one cycle when no_reboot is low. When no_reboot is high, there is no pulse and only the status bits change.
- R7: Writing a one to a status bit clears it, and writing a zero leaves it unchanged. Writing back the value read from a status register returns it to zero.
- R8: Bit 12 (lock) of control register 1, once written to one, keeps reading one after a later write of zero, until reset.
- R9: A byte write to the data-in byte (0x02 low) or the data-out byte (0x03, high half of 0x02) stores the byte and sets bit 1 of status 1.
- R10: An initial value of 0xFFFF reads back as written at 0x12, loads the counter as 0x3FF, and expires 0x3FF ticks after loading.
- R11: Each write changes only the bytes whose byte enable is set. be[0] selects bits 7:0 and be[1] selects bits 15:8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Timebase strobe, one cycle wide |
| no_reboot | input | 1 | Suppresses the action request on a second expiry |
| wr | input | 1 | Register write strobe |
| addr | input | 5 | Byte offset of the addressed 16-bit word (bit 0 ignored) |
| wdata | input | 16 | Write data, little-endian |
| be | input | 2 | Byte enables for wdata |
| rdata | output | 16 | Read data for addr, combinational |
| action_req | output | 1 | One-cycle request for the platform action |

## Verification
The properties assume that tick is never high on two clock cycles in a row. Without that, a zero initial value could expire on back-to-back cycles and make the action request look longer than one cycle. The stimulus raises tick for a single cycle and always follows it with a low cycle. The properties also assume that no_reboot is stable around expiries, and the bench changes it only while the counter is halted or idle. Register accesses are driven just after the clock edge, so every write and tick is seen at exactly one edge.

// File: rtl/wdog_regs.sv
module wdog_regs #(
  parameter int CW = 10
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick,
  input  logic        no_reboot,
  input  logic        wr,
  input  logic [4:0]  addr,
  input  logic [15:0] wdata,
  input  logic [1:0]  be,
  output logic [15:0] rdata,
  output logic        action_req
);
  localparam logic [3:0] W_RLD  = 4'h0, W_DAT = 4'h1, W_ST1 = 4'h2, W_ST2 = 4'h3,
                         W_CT1  = 4'h4, W_CT2 = 4'h5, W_MSG = 4'h6, W_WDS = 4'h7,
                         W_SWI  = 4'h8, W_INI = 4'h9;
  localparam logic [CW-1:0] ONE = CW'(1);

  logic [3:0]    idx;
  logic [CW-1:0] cnt;
  logic [15:0]   init_r, ctrl2;
  logic [7:0]    din, dout, msg1, msg2, wdst, swirq;
  logic          halt, lock, st1_to, st1_sw, st2_sec, st2_boot, stage, act_q;
  logic          reload_wr, expire, second, lo, hi;

  assign idx       = addr[4:1];
  assign lo        = wr & be[0];
  assign hi        = wr & be[1];
  assign reload_wr = wr & (idx == W_RLD) & (|be);
  assign expire    = tick & ~halt & ~reload_wr & (cnt <= ONE);
  assign second    = expire & stage;
  assign action_req = act_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      stage <= 1'b0;
      act_q <= 1'b0;
    end else begin
      act_q <= second & ~no_reboot;
      if (reload_wr) begin
        cnt   <= init_r[CW-1:0];
        stage <= 1'b0;
      end else if (tick && !halt) begin
        cnt <= expire ? init_r[CW-1:0] : cnt - ONE;
        if (expire) stage <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st1_to <= 1'b0; st1_sw <= 1'b0; st2_sec <= 1'b0; st2_boot <= 1'b0;
    end else begin
      st1_to   <= expire | (st1_to   & ~(lo && idx == W_ST1 && wdata[3]));
      st1_sw   <= (wr && idx == W_DAT && (|be)) |
                  (st1_sw & ~(lo && idx == W_ST1 && wdata[1]));
      st2_sec  <= second | (st2_sec  & ~(lo && idx == W_ST2 && wdata[1]));
      st2_boot <= second | (st2_boot & ~(lo && idx == W_ST2 && wdata[2]));
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      halt <= 1'b0; lock <= 1'b0;
      init_r <= 16'h0004; ctrl2 <= 16'h0008;
      din <= '0; dout <= '0; msg1 <= '0; msg2 <= '0; wdst <= '0; swirq <= 8'h03;
    end else begin
      if (hi && idx == W_CT1) begin
        halt <= wdata[11];
        lock <= lock | wdata[12];
      end
      if (lo && idx == W_DAT) din   <= wdata[7:0];
      if (hi && idx == W_DAT) dout  <= wdata[15:8];
      if (lo && idx == W_CT2) ctrl2[7:0]  <= wdata[7:0];
      if (hi && idx == W_CT2) ctrl2[15:8] <= wdata[15:8];
      if (lo && idx == W_MSG) msg1  <= wdata[7:0];
      if (hi && idx == W_MSG) msg2  <= wdata[15:8];
      if (lo && idx == W_WDS) wdst  <= wdata[7:0];
      if (lo && idx == W_SWI) swirq <= wdata[7:0];
      if (lo && idx == W_INI) init_r[7:0]  <= wdata[7:0];
      if (hi && idx == W_INI) init_r[15:8] <= wdata[15:8];
    end
  end

  always_comb begin
    rdata = '0;
    case (idx)
      W_RLD: rdata = 16'(cnt);
      W_DAT: rdata = {dout, din};
      W_ST1: rdata = {12'h000, st1_to, 1'b0, st1_sw, 1'b0};
      W_ST2: rdata = {13'h0000, st2_boot, st2_sec, 1'b0};
      W_CT1: rdata = {3'b000, lock, halt, 11'h000};
      W_CT2: rdata = ctrl2;
      W_MSG: rdata = {msg2, msg1};
      W_WDS: rdata = {8'h00, wdst};
      W_SWI: rdata = {8'h00, swirq};
      W_INI: rdata = init_r;
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/wdog_regs_chk.sv
module wdog_regs_chk #(
  parameter int CW = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick,
  input logic          no_reboot,
  input logic          halt,
  input logic          lock,
  input logic          reload_wr,
  input logic [CW-1:0] cnt,
  input logic          to_sts,
  input logic          sec_sts,
  input logic          action_req
);
  localparam logic [CW-1:0] ONE = CW'(1);

  a_r3_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !halt && !reload_wr && cnt > ONE) |=> cnt == $past(cnt) - ONE);
  a_r3_halt_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (halt && !reload_wr) |=> $stable(cnt));
  a_r4_expiry_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !halt && !reload_wr && cnt <= ONE) |=> to_sts);
  a_r6_action_needs_second: assert property (@(posedge clk) disable iff (!rst_n)
    action_req |-> sec_sts);
  a_r6_action_inhibit: assert property (@(posedge clk) disable iff (!rst_n)
    action_req |-> !$past(no_reboot));
  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    action_req |=> !action_req);
  a_r8_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    lock |=> lock);
endmodule

bind wdog_regs wdog_regs_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .no_reboot(no_reboot),
  .halt(halt), .lock(lock), .reload_wr(reload_wr), .cnt(cnt),
  .to_sts(st1_to), .sec_sts(st2_sec), .action_req(action_req)
);

// File: tb/wdog_regs_tb.sv
module wdog_regs_tb;
  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, no_reboot = 1'b0, wr = 1'b0;
  logic [4:0] addr = '0;
  logic [15:0] wdata = '0;
  logic [1:0] be = '0;
  logic [15:0] rdata;
  logic action_req;
  int checks = 0, fails = 0, act_cnt = 0;

  typedef struct { logic [15:0] exp; string tag; } item_t;
  item_t sb[$];

  always #5 clk = ~clk;

  wdog_regs u_dut (.clk(clk), .rst_n(rst_n), .tick(tick), .no_reboot(no_reboot),
    .wr(wr), .addr(addr), .wdata(wdata), .be(be), .rdata(rdata), .action_req(action_req));

  always @(negedge clk) begin
    if (action_req) act_cnt++;
    if (sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      checks++;
      if (rdata !== it.exp) begin
        fails++;
        $display("FAIL %s: got 0x%04h expected 0x%04h", it.tag, rdata, it.exp);
      end
    end
  end

  task automatic wr_reg(input logic [4:0] a, input logic [15:0] d, input logic [1:0] b);
    @(posedge clk); #2 wr = 1'b1; addr = a; wdata = d; be = b;
    @(posedge clk); #2 wr = 1'b0; be = '0;
  endtask

  task automatic rd_chk(input logic [4:0] a, input logic [15:0] e, input string tag);
    @(posedge clk); #2 addr = a;
    sb.push_back('{exp: e, tag: tag});
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #2 tick = 1'b1;
      @(posedge clk); #2 tick = 1'b0;
    end
  endtask

  task automatic chk_act(input int e, input string tag);
    @(posedge clk); #1;
    checks++;
    if (act_cnt != e) begin
      fails++;
      $display("FAIL %s: got %0d pulses expected %0d", tag, act_cnt, e);
    end
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog: got hung run expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    // R1 reset values
    rd_chk(5'h00, 16'h0000, "R1 reload");
    rd_chk(5'h02, 16'h0000, "R1 data");
    rd_chk(5'h04, 16'h0000, "R1 status1");
    rd_chk(5'h06, 16'h0000, "R1 status2");
    rd_chk(5'h08, 16'h0000, "R1 ctrl1");
    rd_chk(5'h0A, 16'h0008, "R1 ctrl2");
    rd_chk(5'h0C, 16'h0000, "R1 msg");
    rd_chk(5'h0E, 16'h0000, "R1 wdstat");
    rd_chk(5'h10, 16'h0003, "R1 swirq");
    rd_chk(5'h12, 16'h0004, "R1 init");
    wr_reg(5'h08, 16'h0800, 2'b10);
    // R11 byte enables
    wr_reg(5'h0A, 16'hBEEF, 2'b01);
    rd_chk(5'h0A, 16'h00EF, "R11 low byte only");
    wr_reg(5'h0A, 16'h1234, 2'b10);
    rd_chk(5'h0A, 16'h12EF, "R11 high byte only");
    // R9 software event, R7 write-zero and write-one
    wr_reg(5'h02, 16'h5A77, 2'b10);
    rd_chk(5'h02, 16'h5A00, "R9 data-out stored");
    rd_chk(5'h04, 16'h0002, "R9 sw event set");
    wr_reg(5'h04, 16'h0000, 2'b11);
    rd_chk(5'h04, 16'h0002, "R7 zero write keeps");
    wr_reg(5'h04, 16'h0002, 2'b11);
    rd_chk(5'h04, 16'h0000, "R7 one write clears");
    // R2 R4 R5 R6 two-stage expiry
    wr_reg(5'h12, 16'h0005, 2'b11);
    wr_reg(5'h00, 16'h0000, 2'b01);
    rd_chk(5'h00, 16'h0005, "R2 live count loaded");
    wr_reg(5'h08, 16'h0000, 2'b10);
    ticks(4);
    rd_chk(5'h00, 16'h0001, "R3 count after 4 ticks");
    rd_chk(5'h04, 16'h0000, "R4 no flag after N-1");
    ticks(1);
    rd_chk(5'h04, 16'h0008, "R4 flag after N");
    rd_chk(5'h00, 16'h0005, "R4 reload on expiry");
    rd_chk(5'h06, 16'h0000, "R5 no second yet");
    wr_reg(5'h04, 16'h0008, 2'b01);
    rd_chk(5'h04, 16'h0000, "R7 timeout cleared");
    ticks(5);
    rd_chk(5'h06, 16'h0006, "R5 second and boot set");
    rd_chk(5'h04, 16'h0008, "R4 flag again");
    chk_act(1, "R6 action pulse once");
    wr_reg(5'h06, 16'h0006, 2'b01);
    rd_chk(5'h06, 16'h0000, "R7 status2 cleared");
    // R6 inhibited
    wr_reg(5'h08, 16'h0800, 2'b10);
    no_reboot = 1'b1;
    wr_reg(5'h04, 16'h0008, 2'b01);
    wr_reg(5'h00, 16'h0000, 2'b01);
    wr_reg(5'h08, 16'h0000, 2'b10);
    ticks(10);
    rd_chk(5'h06, 16'h0006, "R5 second with inhibit");
    chk_act(1, "R6 no pulse when inhibited");
    // R3 halt
    wr_reg(5'h08, 16'h0800, 2'b10);
    no_reboot = 1'b0;
    wr_reg(5'h00, 16'h0000, 2'b01);
    ticks(3);
    rd_chk(5'h00, 16'h0005, "R3 halt holds count");
    // R10 max value masked
    wr_reg(5'h04, 16'h000A, 2'b01);
    wr_reg(5'h06, 16'h0006, 2'b01);
    wr_reg(5'h12, 16'hFFFF, 2'b11);
    rd_chk(5'h12, 16'hFFFF, "R10 init readback");
    wr_reg(5'h00, 16'h0000, 2'b10);
    rd_chk(5'h00, 16'h03FF, "R10 masked load");
    wr_reg(5'h08, 16'h0000, 2'b10);
    ticks(1022);
    rd_chk(5'h00, 16'h0001, "R10 count before expiry");
    rd_chk(5'h04, 16'h0000, "R10 no flag before expiry");
    ticks(1);
    rd_chk(5'h04, 16'h0008, "R10 flag at expiry");
    chk_act(1, "R6 first expiry no pulse");
    // R8 lock
    wr_reg(5'h08, 16'h1800, 2'b10);
    wr_reg(5'h08, 16'h0000, 2'b10);
    rd_chk(5'h08, 16'h1000, "R8 lock sticky");
    @(posedge clk); @(posedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule